// File: doc/BRIEF.md
# Timer Counter Read-Back Latch Controller

This block is the host read path for a group of three programmable 16-bit down-counters. The counting engines sit outside it. They supply, for each counter, the live count, the output level, the null-count flag, the programmed mode, the BCD flag and the byte access mode. The host talks to the block over a byte-wide bus with four ports. Ports 0, 1 and 2 are the counter data ports, and port 3 takes control words.

A control word can freeze the count, the status byte, or both, for any subset of the counters. Each frozen value stays put until the host reads it through that counter's port. Each counter has its own byte pointer, so a two-byte count always comes out low byte first. A pending status byte is always returned before a pending count. A control word that reprograms a counter discards whatever that counter still has latched.

Top module: `timer_readback_ctrl`

## Requirements
- R1: A write to port 3 with data bits 7:6 = 11 and bit 0 = 0 is a multi-latch command. Bits 1, 2 and 3 select counters 0, 1 and 2. Bit 5 low requests a count latch and bit 4 low requests a status latch. The same command with bit 0 = 1 changes nothing.
- R2: One multi-latch command captures every selected counter in the same cycle. Each counter then keeps its captured values until that counter's own port is read, whatever the live inputs do.
- R3: A count latch request on a counter whose count is still latched is ignored. A status latch request on a counter whose status is still latched is ignored. In both cases the first captured value is the one read.
- R4: The status byte is {out, null_count, rw_mode[1:0], mode[2:0], bcd}, taken at capture time. While a status byte is pending, the next read of that port returns it, whatever order the latches were set in. That read does not move the byte pointer.
- R5: A latched count is read according to rw_mode. With rw_mode 01 it is read as bits 7:0. With rw_mode 10 it is read as bits 15:8. With any other rw_mode it is read as bits 7:0 and then bits 15:8. The latch is released after its last byte.
- R6: With no latch pending, a read returns the live count under the same byte rules. In two-byte mode the pointer of that counter alone toggles on each read.
- R7: A write to port 3 with bits 7:6 = counter number (0..2) and bits 5:4 = 00 latches that counter's count, under the rule of R3.
- R8: A write to port 3 with bits 7:6 = counter number and bits 5:4 not 00 reprograms that counter. Its count latch and status latch are cleared, and its pointer returns to the low byte.
- R9: After a synchronous reset, no latch is pending and every pointer selects the low byte.
- R10: A read of port 3 returns 0x00. Writes to ports 0 to 2 do not change the read path. A read strobe that coincides with a write strobe does not change any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Port number: 0..2 counter ports, 3 control word |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of bus_rd |
| cnt_live | input | 48 | Live counts, counter i at bits 16i+15:16i |
| cnt_out | input | 3 | Output level per counter |
| cnt_null | input | 3 | Null-count flag per counter |
| cnt_mode | input | 9 | Programmed mode, 3 bits per counter |
| cnt_rw | input | 6 | Byte access mode, 2 bits per counter |
| cnt_bcd | input | 3 | BCD flag per counter |

## Verification
A stuck or lost latch flag shows up on the very next read of that counter. The read returns the live value where a frozen one was due, or the reverse. A pointer that has slipped swaps the low and high bytes on the next read, and stays swapped for every pair after it. A capture that overwrote a pending value appears when the host drains the latch, because the returned bytes then differ from the count that was live at the first request. A status that does not take priority shows up as a count byte in place of the status on the first read.

// File: rtl/timer_rb_pkg.sv
package timer_rb_pkg;

  localparam int NUM_CNT = 3;
  localparam int CNT_W   = 16;
  localparam int ADDR_W  = 2;
  localparam logic [ADDR_W-1:0] CTRL_PORT = 2'd3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_LOHI  = 2'b11
  } acc_e;

  function automatic logic is_two_byte(input logic [1:0] rw);
    return !((rw == ACC_LO) || (rw == ACC_HI));
  endfunction

  function automatic logic [7:0] pack_status(input logic outl, input logic nul,
                                             input logic [1:0] rw,
                                             input logic [2:0] mode,
                                             input logic bcd);
    return {outl, nul, rw, mode, bcd};
  endfunction

  function automatic logic [7:0] pick_byte(input logic [CNT_W-1:0] v,
                                           input logic [1:0] rw,
                                           input logic ptr);
    if (rw == ACC_LO)      return v[7:0];
    else if (rw == ACC_HI) return v[15:8];
    else                   return ptr ? v[15:8] : v[7:0];
  endfunction

endpackage

// File: rtl/rb_cmd_decode.sv
module rb_cmd_decode
  import timer_rb_pkg::*;
#(
  parameter int N = NUM_CNT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_evt,
  input  logic [7:0]   wdata,
  output logic [N-1:0] cnt_req,
  output logic [N-1:0] sts_req,
  output logic [N-1:0] reprog
);

  logic is_multi;
  assign is_multi = (wdata[7:6] == 2'b11) && !wdata[0];

  for (genvar i = 0; i < N; i++) begin : g_sel
    logic pick_multi, pick_single;
    assign pick_multi  = is_multi && wdata[1+i];
    assign pick_single = (wdata[7:6] == 2'(i));
    assign cnt_req[i]  = wr_evt && ((pick_multi && !wdata[5]) ||
                                    (pick_single && (wdata[5:4] == ACC_LATCH)));
    assign sts_req[i]  = wr_evt && pick_multi && !wdata[4];
    assign reprog[i]   = wr_evt && pick_single && (wdata[5:4] != ACC_LATCH);
  end

  assert_no_conflict_R7: assert property (@(posedge clk) disable iff (rst)
    ((cnt_req | sts_req) & reprog) == '0);

  assert_ignored_form_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && (wdata[7:6] == 2'b11) && wdata[0]) |-> (sts_req == '0));

endmodule

// File: rtl/rb_lane.sv
module rb_lane
  import timer_rb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_evt,
  input  logic             cnt_req,
  input  logic             sts_req,
  input  logic             reprog,
  input  logic [CNT_W-1:0] live_cnt,
  input  logic             out_lvl,
  input  logic             null_flag,
  input  logic [2:0]       mode,
  input  logic [1:0]       rw,
  input  logic             bcd,
  output logic [7:0]       rdata
);

  logic             cnt_latched, sts_latched, ptr;
  logic [CNT_W-1:0] cnt_hold;
  logic [7:0]       sts_hold;
  logic             two;

  logic cnt_take, sts_take, sts_drain, cnt_byte, cnt_release;

  assign two         = is_two_byte(rw);
  assign cnt_take    = cnt_req && !cnt_latched;
  assign sts_take    = sts_req && !sts_latched;
  assign sts_drain   = rd_evt && sts_latched;
  assign cnt_byte    = rd_evt && !sts_latched;
  assign cnt_release = cnt_byte && cnt_latched && (!two || ptr);

  always_ff @(posedge clk) begin
    if (rst || reprog) begin
      cnt_latched <= 1'b0;
      sts_latched <= 1'b0;
      ptr         <= 1'b0;
    end else begin
      if (sts_drain)         sts_latched <= 1'b0;
      if (cnt_byte && two)   ptr         <= ~ptr;
      if (cnt_release)       cnt_latched <= 1'b0;
      if (cnt_take)          cnt_latched <= 1'b1;
      if (sts_take)          sts_latched <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (cnt_take) cnt_hold <= live_cnt;
    if (sts_take) sts_hold <= pack_status(out_lvl, null_flag, rw, mode, bcd);
  end

  always_comb begin
    if (sts_latched)      rdata = sts_hold;
    else if (cnt_latched) rdata = pick_byte(cnt_hold, rw, ptr);
    else                  rdata = pick_byte(live_cnt, rw, ptr);
  end

  assert_cnt_relatch_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_latched && cnt_req && !reprog) |=> (cnt_hold == $past(cnt_hold)));

  assert_sts_relatch_R3: assert property (@(posedge clk) disable iff (rst)
    (sts_latched && sts_req && !reprog) |=> (sts_hold == $past(sts_hold)));

  assert_status_first_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_evt && sts_latched) |-> (rdata == sts_hold));

  assert_status_keeps_ptr_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_evt && sts_latched && !reprog) |=> (ptr == $past(ptr)));

  assert_reprog_clears_R8: assert property (@(posedge clk) disable iff (rst)
    reprog |=> (!cnt_latched && !sts_latched && !ptr));

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (!rd_evt && !cnt_req && !sts_req && !reprog) |=>
      (cnt_latched == $past(cnt_latched) && sts_latched == $past(sts_latched) &&
       ptr == $past(ptr)));

endmodule

// File: rtl/rb_read_mux.sv
module rb_read_mux
  import timer_rb_pkg::*;
#(
  parameter int N = NUM_CNT
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [N*8-1:0]    lane_data,
  output logic [7:0]        rdata
);

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < N; i++)
      if (addr == ADDR_W'(i)) rdata = lane_data[i*8 +: 8];
  end

endmodule

// File: rtl/timer_readback_ctrl.sv
module timer_readback_ctrl
  import timer_rb_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_rd,
  input  logic                     bus_wr,
  input  logic [7:0]               bus_wdata,
  output logic [7:0]               bus_rdata,
  input  logic [NUM_CNT*CNT_W-1:0] cnt_live,
  input  logic [NUM_CNT-1:0]       cnt_out,
  input  logic [NUM_CNT-1:0]       cnt_null,
  input  logic [NUM_CNT*3-1:0]     cnt_mode,
  input  logic [NUM_CNT*2-1:0]     cnt_rw,
  input  logic [NUM_CNT-1:0]       cnt_bcd
);

  logic               ctrl_wr;
  logic [NUM_CNT-1:0] cnt_req, sts_req, reprog, rd_hit;
  logic [NUM_CNT*8-1:0] lane_data;

  assign ctrl_wr = bus_wr && (bus_addr == CTRL_PORT);

  rb_cmd_decode #(.N(NUM_CNT)) u_decode (
    .clk     (clk),
    .rst     (rst),
    .wr_evt  (ctrl_wr),
    .wdata   (bus_wdata),
    .cnt_req (cnt_req),
    .sts_req (sts_req),
    .reprog  (reprog)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_lane
    assign rd_hit[i] = bus_rd && !bus_wr && (bus_addr == ADDR_W'(i));
    rb_lane u_lane (
      .clk       (clk),
      .rst       (rst),
      .rd_evt    (rd_hit[i]),
      .cnt_req   (cnt_req[i]),
      .sts_req   (sts_req[i]),
      .reprog    (reprog[i]),
      .live_cnt  (cnt_live[i*CNT_W +: CNT_W]),
      .out_lvl   (cnt_out[i]),
      .null_flag (cnt_null[i]),
      .mode      (cnt_mode[i*3 +: 3]),
      .rw        (cnt_rw[i*2 +: 2]),
      .bcd       (cnt_bcd[i]),
      .rdata     (lane_data[i*8 +: 8])
    );
  end

  rb_read_mux #(.N(NUM_CNT)) u_mux (
    .addr      (bus_addr),
    .lane_data (lane_data),
    .rdata     (bus_rdata)
  );

  assert_ctrl_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == CTRL_PORT) |-> (bus_rdata == 8'h00));

  assert_one_lane_read_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_hit));

endmodule

// File: tb/timer_readback_ctrl_bench.sv
module timer_readback_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  bus_addr;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [47:0] cnt_live;
  logic [2:0]  cnt_out, cnt_null, cnt_bcd;
  logic [8:0]  cnt_mode;
  logic [5:0]  cnt_rw;

  logic [15:0] live [3];
  logic [1:0]  m_rw [3];
  logic [2:0]  m_md [3];
  logic        m_cl [3], m_sl [3], m_ptr [3];
  logic [15:0] m_cv [3];
  logic [7:0]  m_sv [3];

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      cnt_live[i*16 +: 16] = live[i];
      cnt_rw[i*2 +: 2]     = m_rw[i];
      cnt_mode[i*3 +: 3]   = m_md[i];
    end
  end

  timer_readback_ctrl u_timer_readback_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_live(cnt_live),
    .cnt_out(cnt_out), .cnt_null(cnt_null), .cnt_mode(cnt_mode),
    .cnt_rw(cnt_rw), .cnt_bcd(cnt_bcd)
  );

  function automatic logic two_byte(input logic [1:0] rw);
    return (rw == 2'b11) || (rw == 2'b00);
  endfunction

  function automatic logic [7:0] exp_byte(input int i);
    logic [15:0] v;
    if (m_sl[i]) return m_sv[i];
    v = m_cl[i] ? m_cv[i] : live[i];
    case (m_rw[i])
      2'b01:   return v[7:0];
      2'b10:   return v[15:8];
      default: return m_ptr[i] ? v[15:8] : v[7:0];
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic model_write(input logic [7:0] d);
    for (int i = 0; i < 3; i++) begin
      logic multi, single;
      multi  = (d[7:6] == 2'b11) && !d[0] && d[1+i];
      single = (d[7:6] == 2'(i));
      if (single && d[5:4] != 2'b00) begin
        m_cl[i] = 0; m_sl[i] = 0; m_ptr[i] = 0;
        m_rw[i] = d[5:4]; m_md[i] = d[3:1]; cnt_bcd[i] = d[0];
      end else begin
        if (((multi && !d[5]) || (single && d[5:4] == 2'b00)) && !m_cl[i]) begin
          m_cl[i] = 1; m_cv[i] = live[i];
        end
        if (multi && !d[4] && !m_sl[i]) begin
          m_sl[i] = 1;
          m_sv[i] = {cnt_out[i], cnt_null[i], m_rw[i], m_md[i], cnt_bcd[i]};
        end
      end
    end
  endtask

  task automatic model_read(input int i);
    if (m_sl[i]) m_sl[i] = 0;
    else begin
      if (m_cl[i] && (!two_byte(m_rw[i]) || m_ptr[i])) m_cl[i] = 0;
      if (two_byte(m_rw[i])) m_ptr[i] = ~m_ptr[i];
    end
  endtask

  task automatic bus_op(input logic [1:0] a, input logic r, input logic w,
                        input logic [7:0] d, input string tag);
    string t;
    @(negedge clk);
    bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = d;
    #2;
    if (r) begin
      if (a == 2'd3) check((tag == "") ? "R10" : tag, bus_rdata, 8'h00);
      else if (!w) begin
        t = tag;
        if (t == "") t = m_sl[a] ? "R4" : (m_cl[a] ? "R5" : "R6");
        check(t, bus_rdata, exp_byte(int'(a)));
      end
    end
    @(posedge clk); #1;
    if (w && a == 2'd3) model_write(d);
    else if (r && !w && a != 2'd3) model_read(int'(a));
    bus_rd = 0; bus_wr = 0;
  endtask

  task automatic rd(input int i, input string tag);
    bus_op(2'(i), 1'b1, 1'b0, 8'h00, tag);
  endtask

  task automatic cw(input logic [7:0] d);
    bus_op(2'd3, 1'b0, 1'b1, d, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1; bus_addr = 0; bus_rd = 0; bus_wr = 0; bus_wdata = 0;
    cnt_out = 3'b010; cnt_null = 3'b001; cnt_bcd = 3'b000;
    for (int i = 0; i < 3; i++) begin
      live[i] = 16'hA55A + 16'(i * 16'h1111);
      m_rw[i] = 2'b11; m_md[i] = 3'(i);
      m_cl[i] = 0; m_sl[i] = 0; m_ptr[i] = 0; m_cv[i] = 0; m_sv[i] = 0;
    end
    repeat (3) @(posedge clk); #1;
    rst = 0;

    // R9: pointers start at the low byte
    rd(0, "R9"); rd(0, "R9");
    rd(2, "R9");

    // R7: single counter latch, then live after release (R6)
    cw(8'h00); live[0] = 16'h1234;
    rd(0, "R7"); rd(0, "R7"); rd(0, "R6"); rd(0, "R6");

    // R3: relatch ignored before read
    cw(8'h40); live[1] = 16'hBEEF; cw(8'h40); live[1] = 16'hCAFE;
    rd(1, "R3"); rd(1, "R3");

    // R1, R2: multi-latch of all three counters, count only
    rd(2, "R6");
    cw(8'hDE);
    for (int i = 0; i < 3; i++) live[i] = live[i] ^ 16'hF0F0;
    for (int i = 0; i < 3; i++) begin rd(i, "R2"); rd(i, "R2"); end
    // R1: bit 0 set means ignored
    cw(8'hDF); live[1] = 16'h7766; rd(1, "R1"); rd(1, "R1");

    // R4: count latched before status, status still read first
    cw(8'hD8); cnt_out[2] = 1'b1; cw(8'hE8); live[2] = 16'h0101;
    rd(2, "R4"); rd(2, "R4"); rd(2, "R4"); rd(2, "R6");

    // R8: reprogram clears pending latches, R5 one-byte modes
    cw(8'hC2); cw(8'h14); live[0] = 16'h9A8B;
    rd(0, "R8"); rd(0, "R8");
    cw(8'h00); live[0] = 16'h4433; rd(0, "R5"); rd(0, "R5");
    cw(8'h66); cw(8'h40); live[1] = 16'h2211; rd(1, "R5"); rd(1, "R5");

    // R10: control port reads zero; strobe overlap leaves state alone
    rd(3, "R10");
    cw(8'h70); rd(1, "R10");
    bus_op(2'd1, 1'b1, 1'b1, 8'h5A, "R10");
    bus_op(2'd1, 1'b0, 1'b1, 8'hA5, "R10");
    rd(1, "R10");

    // randomized mix
    for (int n = 0; n < 3000; n++) begin
      int k, c;
      k = $urandom_range(0, 99);
      c = $urandom_range(0, 2);
      if (k < 50) rd(c, "");
      else if (k < 70) cw({2'b11, 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
                           1'($urandom_range(0, 5) == 0)});
      else if (k < 78) cw({2'(c), 2'b00, 4'($urandom_range(0, 15))});
      else if (k < 83) cw({2'(c), 2'($urandom_range(1, 3)), 4'($urandom_range(0, 15))});
      else if (k < 87) bus_op(2'(c), 1'($urandom_range(0, 1)), 1'b1, 8'($urandom), "R10");
      else if (k < 89) rd(3, "R10");
      else begin
        live[c]  = 16'($urandom);
        cnt_out  = 3'($urandom);
        cnt_null = 3'($urandom);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule